// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This engine sits on the controller side of a byte-wide parallel flash bus. Another agent issues a program or erase command sequence to the flash. Once that sequence has been written, a one-cycle start pulse hands the bus to this engine. It then decides, by polling the flash's status byte, whether the embedded operation has finished cleanly or has failed.

The engine reads the status byte in pairs and compares the toggle bit (bit 6) across each pair. A steady toggle bit means the operation is complete and array reads may resume.

When the toggle bit is still moving, the engine looks at the time-limit flag (bit 5) of the newer read:
- If that flag is clear, the engine polls another pair.
- If the flag is set, the engine takes exactly one more pair. The toggling may have stopped in the same moment the flag rose, so the flag alone does not decide failure.

A programmable ceiling on the number of toggling pairs ends a poll that would otherwise never settle. Every failure path writes the byte F0h to the bus, which returns the flash to array-read mode. Only after that write does the engine report the result.

Each bus transfer is a level request that is held until the bus returns a one-cycle acknowledge. The engine samples read data only in the acknowledge cycle.

Top module: `toggle_poll_engine`

## Requirements
- R1: After reset, done_o, pass_o, fail_o and bus_req_o are all low.
- R2: A start pulse in idle raises bus_req_o with bus_we_o low in the next cycle, beginning a pair of status reads.
- R3: If bit 6 is equal in both reads of a pair, the poll ends as passed: done_o and pass_o rise in the cycle after the second read's acknowledge, and no write is issued.
- R4: If bit 6 differs within a pair and bit 5 of the second read is 0, another pair is read. Bit 5 of the first read of a pair has no effect.
- R5: If bit 6 differs and bit 5 of the second read is 1, exactly one more pair is read, whatever the poll limit. If bit 6 is steady in that pair, the result is pass.
- R6: If bit 6 still differs in that extra pair, the engine issues one write transfer (bus_we_o high, bus_wdata_o = F0h). done_o and fail_o rise in the cycle after that write's acknowledge.
- R7: When the number of toggling pairs with bit 5 clear reaches max_polls_i, the poll ends with the F0h write and a fail result. A limit of 0 acts as 1. max_polls_i must be held stable during a poll.
- R8: A transfer completes only in a cycle with bus_ack_i high. bus_req_o and bus_we_o hold until then, and bus_rdata_i is ignored in every other cycle.
- R9: A start pulse while a poll is in progress is ignored: it neither restarts the sequence nor adds a result.
- R10: done_o lasts one cycle, and in that cycle exactly one of pass_o and fail_o is high. Both are low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin polling |
| max_polls_i | input | CNT_W | Ceiling on toggling pairs with bit 5 clear |
| bus_req_o | output | 1 | Transfer request, held until acknowledged |
| bus_we_o | output | 1 | High for the reset write, low for status reads |
| bus_wdata_o | output | DATA_W | Write byte (F0h during the reset write) |
| bus_ack_i | input | 1 | One-cycle transfer acknowledge; read data valid |
| bus_rdata_i | input | DATA_W | Status byte returned by the flash |
| done_o | output | 1 | Poll finished (one-cycle pulse) |
| pass_o | output | 1 | Operation completed (pulse with done_o) |
| fail_o | output | 1 | Operation failed (pulse with done_o) |

## Verification
Every result is due in a fixed cycle relative to the bus:
- The request rises one cycle after start.
- done_o, together with pass_o or fail_o, rises in the cycle right after the deciding acknowledge: the second read of a passing pair, or the F0h write.

The bench's bus model logs each acknowledged transfer at the falling edge after the edge that consumed it. At that same falling edge it requires done_o to be present for the final transfer and absent otherwise. Read and write counts per poll are compared against the queued expectation when done_o appears. Random-looking data presented outside acknowledge cycles, and varied acknowledge latency, test that nothing is sampled early.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_A   = 2'd1,
    ST_RD_B   = 2'd2,
    ST_RST_WR = 2'd3
  } tbp_state_e;

  typedef enum logic [1:0] {
    V_PASS    = 2'd0,
    V_AGAIN   = 2'd1,
    V_RECHECK = 2'd2,
    V_FAIL    = 2'd3
  } tbp_verdict_e;

  localparam int TOG_BIT = 6;
  localparam int TMO_BIT = 5;
  localparam logic [7:0] RESET_CMD = 8'hF0;

  function automatic logic bit_moved(input logic first, input logic second);
    return first ^ second;
  endfunction

  // Decision after the second read of a pair; order sets precedence.
  function automatic tbp_verdict_e judge(input logic moved, input logic tmo,
                                         input logic rechk, input logic at_limit);
    if (!moved)        return V_PASS;
    else if (rechk)    return V_FAIL;
    else if (tmo)      return V_RECHECK;
    else if (at_limit) return V_FAIL;
    else               return V_AGAIN;
  endfunction

endpackage

// File: rtl/tbp_pair_cmp.sv
module tbp_pair_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_i,
  input  logic cur_bit_i,
  output logic moved_o
);
  import tbp_pkg::*;

  logic first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     first_q <= 1'b0;
    else if (cap_i) first_q <= cur_bit_i;
  end

  assign moved_o = bit_moved(first_q, cur_bit_i);

endmodule

// File: rtl/tbp_poll_ctr.sv
module tbp_poll_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             last_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] count_q;

  function automatic logic limit_reached(input logic [CNT_W-1:0] cnt,
                                         input logic [CNT_W-1:0] lim);
    logic [EXT_W-1:0] nxt;
    nxt = {1'b0, cnt} + EXT_W'(1);
    return nxt >= {1'b0, lim};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= '0;
    else if (clr_i) count_q <= '0;
    else if (inc_i) count_q <= count_q + CNT_W'(1);
  end

  assign last_o = limit_reached(count_q, limit_i);

  // R7: with a stable non-zero limit the counter never reaches it
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_i != '0 && $stable(limit_i)) |-> (count_q < limit_i));

endmodule

// File: rtl/tbp_fsm.sv
module tbp_fsm #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ack_i,
  input  logic              tmo_bit_i,
  input  logic              moved_i,
  input  logic              last_i,
  output logic              req_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              cap_o,
  output logic              ctr_clr_o,
  output logic              ctr_inc_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o
);
  import tbp_pkg::*;

  tbp_state_e   state_q, state_d;
  tbp_verdict_e verdict;
  logic rechk_q, set_rechk, fin_pass, fin_fail;
  logic done_q, pass_q, fail_q;

  assign verdict = judge(moved_i, tmo_bit_i, rechk_q, last_i);

  always_comb begin
    state_d   = state_q;
    cap_o     = 1'b0;
    ctr_clr_o = 1'b0;
    ctr_inc_o = 1'b0;
    set_rechk = 1'b0;
    fin_pass  = 1'b0;
    fin_fail  = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d   = ST_RD_A;
        ctr_clr_o = 1'b1;
      end
      ST_RD_A: if (ack_i) begin
        cap_o   = 1'b1;
        state_d = ST_RD_B;
      end
      ST_RD_B: if (ack_i) begin
        case (verdict)
          V_PASS:    begin fin_pass  = 1'b1; state_d = ST_IDLE; end
          V_AGAIN:   begin ctr_inc_o = 1'b1; state_d = ST_RD_A; end
          V_RECHECK: begin set_rechk = 1'b1; state_d = ST_RD_A; end
          default:   state_d = ST_RST_WR;
        endcase
      end
      ST_RST_WR: if (ack_i) begin
        fin_fail = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rechk_q <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ctr_clr_o)      rechk_q <= 1'b0;
      else if (set_rechk) rechk_q <= 1'b1;
      done_q <= fin_pass | fin_fail;
      pass_q <= fin_pass;
      fail_q <= fin_fail;
    end
  end

  assign req_o   = (state_q != ST_IDLE);
  assign we_o    = (state_q == ST_RST_WR);
  assign wdata_o = we_o ? DATA_W'(RESET_CMD) : '0;
  assign done_o  = done_q;
  assign pass_o  = pass_q;
  assign fail_o  = fail_q;

  // R10: one result per done pulse, and the pulse is one cycle long
  p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pass_o ^ fail_o));
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8: without an acknowledge the sequencer does not advance
  p_hold_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(we_o)));
  // R9: a start during a poll does not wipe the recheck state
  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rechk_q && req_o && start_i) |=> rechk_q);
  // R6: a fail result always follows an acknowledged reset write
  p_fail_after_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> $past(we_o && ack_i));
  // R3: a pass result always follows an acknowledged read
  p_pass_after_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> $past(req_o && !we_o && ack_i));

endmodule

// File: rtl/toggle_poll_engine.sv
module toggle_poll_engine #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  max_polls_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o
);
  import tbp_pkg::*;

  logic cap_first, pair_moved, at_limit, ctr_clr, ctr_inc;
  logic tog_bit, tmo_bit;
  logic rd_unused;

  assign tog_bit   = bus_rdata_i[TOG_BIT];
  assign tmo_bit   = bus_rdata_i[TMO_BIT];
  assign rd_unused = ^{bus_rdata_i[DATA_W-1:TOG_BIT+1], bus_rdata_i[TMO_BIT-1:0]};

  tbp_pair_cmp u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_i     (cap_first),
    .cur_bit_i (tog_bit),
    .moved_o   (pair_moved)
  );

  tbp_poll_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (ctr_clr),
    .inc_i   (ctr_inc),
    .limit_i (max_polls_i),
    .last_o  (at_limit)
  );

  tbp_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ack_i     (bus_ack_i),
    .tmo_bit_i (tmo_bit),
    .moved_i   (pair_moved),
    .last_i    (at_limit),
    .req_o     (bus_req_o),
    .we_o      (bus_we_o),
    .wdata_o   (bus_wdata_o),
    .cap_o     (cap_first),
    .ctr_clr_o (ctr_clr),
    .ctr_inc_o (ctr_inc),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .fail_o    (fail_o)
  );

  // R2: the first read of a pair is captured only from an acknowledged read
  p_cap_on_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_first |-> (bus_ack_i && bus_req_o && !bus_we_o));

endmodule

// File: tb/toggle_poll_engine_tb.sv
module toggle_poll_engine_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] max_polls_i = 16'd4;
  logic        bus_req_o, bus_we_o, done_o, pass_o, fail_o;
  logic [7:0]  bus_wdata_o;
  logic        bus_ack_i = 1'b0;
  logic [7:0]  bus_rdata_i = 8'h5A;

  toggle_poll_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .max_polls_i(max_polls_i),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_wdata_o(bus_wdata_o),
    .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i),
    .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
  );

  typedef struct {
    bit    pass;
    int    reads;
    int    writes;
    string tag;
  } exp_t;

  int   checks = 0;
  int   errors = 0;
  logic [7:0] stat_q[$];
  exp_t exp_q[$];
  int   lat = 0;
  int   wait_cnt = 0;
  logic ack_we = 1'b0;
  logic [7:0] ack_wdata = 8'h00;
  int   n_reads = 0;
  int   n_wr = 0;
  logic done_prev = 1'b0;
  logic req_prev = 1'b0;
  int   cyc = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // Bus model and monitor: logs transfers consumed at the previous posedge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (req_prev && !bus_ack_i)
        check(bus_req_o, "R8", "request held while unacknowledged", bus_req_o, 1);
      if (bus_ack_i) begin
        if (ack_we) begin
          n_wr++;
          check(ack_wdata == 8'hF0, "R6", "reset write byte", ack_wdata, 8'hF0);
        end else begin
          n_reads++;
        end
      end
      if (done_o) begin
        check(bus_ack_i, "R10", "done in cycle after final ack", 0, 1);
        check(!done_prev, "R10", "done single cycle", done_prev, 0);
        check(pass_o ^ fail_o, "R10", "exactly one result", {pass_o, fail_o}, 1);
        if (exp_q.size() == 0) begin
          check(0, "R9", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(pass_o == e.pass, e.tag, "pass result", pass_o, e.pass);
          check(fail_o == !e.pass, e.tag, "fail result", fail_o, !e.pass);
          check(n_reads == e.reads, e.tag, "status reads", n_reads, e.reads);
          check(n_wr == e.writes, e.tag, "reset writes", n_wr, e.writes);
        end
        n_reads = 0;
        n_wr = 0;
      end else begin
        check(!pass_o && !fail_o, "R10", "result without done", {pass_o, fail_o}, 0);
      end
      done_prev = done_o;
      if (bus_ack_i) begin
        bus_ack_i   = 1'b0;
        wait_cnt    = lat;
        bus_rdata_i = 8'h64 ^ 8'(cyc);
      end else if (bus_req_o) begin
        if (wait_cnt == 0) begin
          bus_ack_i = 1'b1;
          ack_we    = bus_we_o;
          ack_wdata = bus_wdata_o;
          if (!bus_we_o) bus_rdata_i = (stat_q.size() != 0) ? stat_q.pop_front() : 8'h00;
        end else begin
          wait_cnt--;
          bus_rdata_i = 8'h60 ^ 8'(cyc * 3);
        end
      end
      req_prev = bus_req_o;
    end
  end

  task automatic run(input logic [15:0] maxp, input int latency, input bit pass,
                     input int reads, input int writes, input bit busy_start,
                     input string tag);
    exp_t e;
    e.pass = pass; e.reads = reads; e.writes = writes; e.tag = tag;
    @(negedge clk);
    lat = latency;
    wait_cnt = latency;
    max_polls_i = maxp;
    exp_q.push_back(e);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(bus_req_o && !bus_we_o, "R2", "read request after start", {bus_req_o, bus_we_o}, 2);
    if (busy_start) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
    check(stat_q.size() == 0, tag, "status bytes consumed", stat_q.size(), 0);
    check(!bus_req_o, tag, "bus idle after result", bus_req_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({done_o, pass_o, fail_o, bus_req_o} == 4'b0, "R1", "reset outputs",
          {done_o, pass_o, fail_o, bus_req_o}, 0);
    // R3: steady toggle bit on first pair
    stat_q = '{8'h00, 8'h00};
    run(16'd4, 0, 1'b1, 2, 0, 1'b0, "R3");
    // R4 and R9: toggle then steady, start pulsed mid-poll
    stat_q = '{8'h40, 8'h00, 8'h00, 8'h00};
    run(16'd4, 2, 1'b1, 4, 0, 1'b1, "R9");
    // R4: bit 5 on the first read of a pair is ignored
    stat_q = '{8'h20, 8'h40, 8'h00, 8'h00};
    run(16'd4, 1, 1'b1, 4, 0, 1'b0, "R4");
    // R5: timeout flag, recheck steady -> pass
    stat_q = '{8'h00, 8'h60, 8'h60, 8'h60};
    run(16'd4, 0, 1'b1, 4, 0, 1'b0, "R5");
    // R6: timeout flag, recheck still toggling -> reset write, fail
    stat_q = '{8'h00, 8'h60, 8'h20, 8'h60};
    run(16'd4, 1, 1'b0, 4, 1, 1'b0, "R6");
    // R3 again after a fail
    stat_q = '{8'h40, 8'h40};
    run(16'd4, 3, 1'b1, 2, 0, 1'b0, "R3");
    // R7: limit 0 acts as 1
    stat_q = '{8'h00, 8'h40};
    run(16'd0, 0, 1'b0, 2, 1, 1'b0, "R7");
    // R7: limit 3 reached after three toggling pairs
    stat_q = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40};
    run(16'd3, 1, 1'b0, 6, 1, 1'b0, "R7");
    // R5: timeout flag takes precedence over a reached limit
    stat_q = '{8'h00, 8'h60, 8'h40, 8'h40};
    run(16'd1, 0, 1'b1, 4, 0, 1'b0, "R5");
    // R8: long latency, one toggling pair then steady under limit 2
    stat_q = '{8'h00, 8'h40, 8'h40, 8'h40};
    run(16'd2, 3, 1'b1, 4, 0, 1'b0, "R8");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog: actual=%0h expected=%0h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule